// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

A bank of up to 32 general-purpose pins behind a small synchronous register port. Each pin is set up on its own as a plain input, a driven output, or an interrupt source. An interrupt source can watch for a high or low level, for a rising or falling edge, or for edges in both directions.

Every pad input passes through a two-stage synchroniser. It is then gated by a per-pin input enable, so a disabled pin reads as 0. Edge events are held in a pending latch until software writes ones to a clear register. Level events are shown live and are not held. The mask is opened one bit at a time through a set register, and it is closed by writing zeros to the mask register itself. A single interrupt request is raised while any pin is both pending and unmasked.

Software drives the port with one-cycle write and read strobes. Read data appears on the cycle after the read strobe.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, pad_oe and pad_out are 0 and irq is low.
- R2: pad_oe bit i is 1 only when MODE bit i is 0 and DIR bit i is 1, and pad_out bit i then equals OUTV bit i. Otherwise both bits are 0.
- R3: PIN returns the synchronised pad level ANDed with INEN, including for pins set as outputs. A pin whose INEN bit is 0 reads 0.
- R4: A pin with MODE=1 and EDGE=0 shows PEND equal to its PIN level XOR POL (POL=0 active high, POL=1 active low). The bit follows the level and is not held.
- R5: A pin with MODE=1, EDGE=1 and DUAL=0 sets its PEND bit on a rising PIN edge when POL=0, or on a falling edge when POL=1. The bit stays set through later edges until it is cleared.
- R6: With MODE=1, EDGE=1 and DUAL=1, both a rising and a falling PIN edge set the PEND bit.
- R7: Writing PCLR clears the held edge status of every pin whose written bit is 1. Pins written with 0 are unchanged. PCLR reads 0.
- R8: A write to MASK clears the mask bits written as 0 and leaves the others unchanged. A write to MSET sets the mask bits written as 1. MSET reads 0.
- R9: irq is high exactly when some pin has both its PEND and its MASK bit set.
- R10: Byte offsets are INEN 0x00, MODE 0x04, DIR 0x08, OUTV 0x0C, PIN 0x10, POL 0x14, EDGE 0x18, DUAL 0x1C, PEND 0x20, PCLR 0x24, MASK 0x28 and MSET 0x2C, with bit i belonging to pin i. Read data is valid on the cycle after the read strobe. Unmapped or misaligned addresses read 0 and are not written.
- R11: A pin with MODE=0 reads 0 in PEND, and any edge status it held is discarded. It is not restored when MODE returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Byte address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, one cycle after reg_rd |
| pad_in | input | NPINS | Pad input levels, asynchronous |
| pad_out | output | NPINS | Pad output data |
| pad_oe | output | NPINS | Pad output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench aims at the following mistakes:
- **Held level status.** Level pins are driven low again without a clear, which catches a design that latches level status.
- **Wrong edge selection.** Edge pins receive the opposite edge after an event, which catches a design that clears on the return edge or decodes POL backwards.
- **Zero-bit clears.** A PCLR write of all zeros catches a clear that acts on 0 bits.
- **Wrong mask write.** A MASK write that mixes ones and zeros catches a design that copies the word instead of ANDing it.
- **Stale edge status.** Switching a pending pin to general mode and back catches status that survives the switch.
- **Random mixtures.** Random mixtures of mode, polarity, input enable and pad changes are scored against a bench model of pending and irq.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // word index of each register, byte offset = index * 4
  typedef enum logic [3:0] {
    RI_INEN = 4'd0,
    RI_MODE = 4'd1,
    RI_DIR  = 4'd2,
    RI_OUTV = 4'd3,
    RI_PIN  = 4'd4,
    RI_POL  = 4'd5,
    RI_EDGE = 4'd6,
    RI_DUAL = 4'd7,
    RI_PEND = 4'd8,
    RI_PCLR = 4'd9,
    RI_MASK = 4'd10,
    RI_MSET = 4'd11
  } reg_idx_e;
  localparam int IDX_W = 4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] in_en,
  output logic [NPINS-1:0] pin_q,
  output logic [NPINS-1:0] pin_prev
);
  logic [NPINS-1:0] meta_q;
  logic [NPINS-1:0] sync_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i]   <= 1'b0;
        sync_q[i]   <= 1'b0;
        pin_prev[i] <= 1'b0;
      end else begin
        meta_q[i]   <= pad_in[i];
        sync_q[i]   <= meta_q[i];
        pin_prev[i] <= pin_q[i];
      end
    end
    assign pin_q[i] = sync_q[i] & in_en[i];
  end
endmodule

// File: rtl/gpio_sense.sv
module gpio_sense #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_q,
  input  logic [NPINS-1:0] pin_prev,
  input  logic [NPINS-1:0] cfg_mode,
  input  logic [NPINS-1:0] cfg_edge,
  input  logic [NPINS-1:0] cfg_pol,
  input  logic [NPINS-1:0] cfg_dual,
  input  logic [NPINS-1:0] clr_vec,
  output logic [NPINS-1:0] pend
);
  logic [NPINS-1:0] lat_q;
  logic [NPINS-1:0] lat_d;
  logic [NPINS-1:0] hit;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_comb begin
      if (cfg_dual[i])
        hit[i] = pin_q[i] ^ pin_prev[i];
      else if (cfg_pol[i])
        hit[i] = pin_prev[i] & ~pin_q[i];
      else
        hit[i] = pin_q[i] & ~pin_prev[i];
      // a fresh edge wins over a clear in the same cycle
      if (cfg_mode[i] && cfg_edge[i])
        lat_d[i] = (lat_q[i] & ~clr_vec[i]) | hit[i];
      else
        lat_d[i] = 1'b0;
      if (!cfg_mode[i])
        pend[i] = 1'b0;
      else if (cfg_edge[i])
        pend[i] = lat_q[i];
      else
        pend[i] = pin_q[i] ^ cfg_pol[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q[i] <= 1'b0;
      else        lat_q[i] <= lat_d[i];
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NPINS-1:0] pin_q,
  input  logic [NPINS-1:0] pend,
  output logic [NPINS-1:0] cfg_en,
  output logic [NPINS-1:0] cfg_mode,
  output logic [NPINS-1:0] cfg_dir,
  output logic [NPINS-1:0] cfg_outv,
  output logic [NPINS-1:0] cfg_pol,
  output logic [NPINS-1:0] cfg_edge,
  output logic [NPINS-1:0] cfg_dual,
  output logic [NPINS-1:0] mask_q,
  output logic [NPINS-1:0] clr_vec
);
  localparam int IDX_LSB = 2;
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  logic             addr_ok;
  reg_idx_e         idx;
  logic             wr_hit;
  logic [NPINS-1:0] wpins;
  logic [NPINS-1:0] en_d, mode_d, dir_d, outv_d, pol_d, edge_d, dual_d, mask_d;
  logic [DW-1:0]    rd_mux;

  function automatic logic [DW-1:0] widen(input logic [NPINS-1:0] v);
    logic [DW-1:0] w;
    w = '0;
    w[NPINS-1:0] = v;
    return w;
  endfunction

  assign addr_ok = (reg_addr[AW-1:IDX_MSB+1] == '0) && (reg_addr[1:0] == 2'b00);
  assign idx     = reg_idx_e'(reg_addr[IDX_MSB:IDX_LSB]);
  assign wr_hit  = reg_wr && addr_ok;
  assign wpins   = reg_wdata[NPINS-1:0];
  assign clr_vec = (wr_hit && idx == RI_PCLR) ? wpins : '0;

  always_comb begin
    en_d   = cfg_en;
    mode_d = cfg_mode;
    dir_d  = cfg_dir;
    outv_d = cfg_outv;
    pol_d  = cfg_pol;
    edge_d = cfg_edge;
    dual_d = cfg_dual;
    mask_d = mask_q;
    if (wr_hit) begin
      case (idx)
        RI_INEN: en_d   = wpins;
        RI_MODE: mode_d = wpins;
        RI_DIR:  dir_d  = wpins;
        RI_OUTV: outv_d = wpins;
        RI_POL:  pol_d  = wpins;
        RI_EDGE: edge_d = wpins;
        RI_DUAL: dual_d = wpins;
        RI_MASK: mask_d = mask_q & wpins;
        RI_MSET: mask_d = mask_q | wpins;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_ok) begin
      case (idx)
        RI_INEN: rd_mux = widen(cfg_en);
        RI_MODE: rd_mux = widen(cfg_mode);
        RI_DIR:  rd_mux = widen(cfg_dir);
        RI_OUTV: rd_mux = widen(cfg_outv);
        RI_PIN:  rd_mux = widen(pin_q);
        RI_POL:  rd_mux = widen(cfg_pol);
        RI_EDGE: rd_mux = widen(cfg_edge);
        RI_DUAL: rd_mux = widen(cfg_dual);
        RI_PEND: rd_mux = widen(pend);
        RI_MASK: rd_mux = widen(mask_q);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en   <= '0;
      cfg_mode <= '0;
      cfg_dir  <= '0;
      cfg_outv <= '0;
      cfg_pol  <= '0;
      cfg_edge <= '0;
      cfg_dual <= '0;
      mask_q   <= '0;
    end else if (wr_hit) begin
      cfg_en   <= en_d;
      cfg_mode <= mode_d;
      cfg_dir  <= dir_d;
      cfg_outv <= outv_d;
      cfg_pol  <= pol_d;
      cfg_edge <= edge_d;
      cfg_dual <= dual_d;
      mask_q   <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPINS = 32,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);
  logic [NPINS-1:0] cfg_en, cfg_mode, cfg_dir, cfg_outv;
  logic [NPINS-1:0] cfg_pol, cfg_edge, cfg_dual, mask_q, clr_vec;
  logic [NPINS-1:0] pin_q, pin_prev, pend;

  gpio_regs #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_q(pin_q), .pend(pend),
    .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_dir(cfg_dir),
    .cfg_outv(cfg_outv), .cfg_pol(cfg_pol), .cfg_edge(cfg_edge),
    .cfg_dual(cfg_dual), .mask_q(mask_q), .clr_vec(clr_vec)
  );

  gpio_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .in_en(cfg_en),
    .pin_q(pin_q), .pin_prev(pin_prev)
  );

  gpio_sense #(.NPINS(NPINS)) u_sense (
    .clk(clk), .rst_n(rst_n), .pin_q(pin_q), .pin_prev(pin_prev),
    .cfg_mode(cfg_mode), .cfg_edge(cfg_edge), .cfg_pol(cfg_pol),
    .cfg_dual(cfg_dual), .clr_vec(clr_vec), .pend(pend)
  );

  assign pad_oe  = ~cfg_mode & cfg_dir;
  assign pad_out = cfg_outv & pad_oe;
  assign irq     = |(pend & mask_q);
endmodule

module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [AW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic [DW-1:0]    reg_rdata,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic             irq,
  input logic [NPINS-1:0] cfg_mode,
  input logic [NPINS-1:0] cfg_en,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] pend,
  input logic [NPINS-1:0] pin_q
);
  localparam logic [AW-1:0] A_MASK = AW'({RI_MASK, 2'b00});
  localparam logic [AW-1:0] A_MSET = AW'({RI_MSET, 2'b00});
  localparam logic [AW-1:0] A_PCLR = AW'({RI_PCLR, 2'b00});

  // R2
  out_within_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);
  // R2
  no_drive_in_irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & cfg_mode) == '0);
  // R3
  pin_gated_by_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_q & ~cfg_en) == '0);
  // R11
  no_pend_in_gpio_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~cfg_mode) == '0);
  // R8
  mask_write_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MASK) |=> (mask_q & ~$past(mask_q)) == '0);
  // R8
  mset_sets_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MSET) |=>
      (mask_q & $past(reg_wdata[NPINS-1:0])) == $past(reg_wdata[NPINS-1:0]));
  // R7
  pclr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_PCLR) |=> reg_rdata == '0);
  // R9
  irq_off_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_chk (.*);

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;
  localparam int NP = 32;
  localparam logic [7:0] A_INEN = 8'h00, A_MODE = 8'h04, A_DIR = 8'h08,
    A_OUTV = 8'h0C, A_PIN = 8'h10, A_POL = 8'h14, A_EDGE = 8'h18,
    A_DUAL = 8'h1C, A_PEND = 8'h20, A_PCLR = 8'h24, A_MASK = 8'h28,
    A_MSET = 8'h2C;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr, reg_rd;
  logic [7:0]    reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic [NP-1:0] pad_in, pad_out, pad_oe;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  gpio_irq_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_pend(input logic [31:0] mode, edg, pol, lat, q);
    return mode & ((edg & lat) | (~edg & (q ^ pol)));
  endfunction

  function automatic logic [31:0] exp_hit(input logic [31:0] mode, edg, pol, dual, qo, qn);
    logic [31:0] one;
    one = (pol & qo & ~qn) | (~pol & ~qo & qn);
    return mode & edg & ((dual & (qo ^ qn)) | (~dual & one));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] en, mode, dir, outv, pol, edg, dual, msk, pold, pnew, lat, clr, qo, qn, ep;
    void'($urandom(32'd1234));
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 12; i++) rd_chk("R1 reg", 8'(i * 4), 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 pad drive
    wr(A_DIR, 32'h0000_000F);
    wr(A_OUTV, 32'h0000_0005);
    chk("R2 oe", pad_oe, 32'h0000_000F);
    chk("R2 out", pad_out, 32'h0000_0005);
    wr(A_MODE, 32'h0000_0001);
    chk("R2 oe irq-mode", pad_oe, 32'h0000_000E);
    chk("R2 out irq-mode", pad_out, 32'h0000_0004);
    wr(A_MODE, 32'h0); wr(A_DIR, 32'h0); wr(A_OUTV, 32'h0);

    // R3 input enable gating
    pad_in = 32'hA5A5_FFFF;
    settle();
    rd_chk("R3 disabled", A_PIN, 32'h0);
    wr(A_INEN, 32'hFFFF_0F0F);
    settle();
    rd_chk("R3 gated", A_PIN, 32'hA5A5_0F0F);
    wr(A_INEN, 32'hFFFF_FFFF);
    wr(A_DIR, 32'h0000_00FF);
    settle();
    rd_chk("R3 output pin read", A_PIN, 32'hA5A5_FFFF);
    wr(A_DIR, 32'h0);
    pad_in = '0;
    settle();

    // R4 level sensing
    wr(A_MODE, 32'h1);
    rd_chk("R4 idle", A_PEND, 32'h0);
    pad_in = 32'h1; settle();
    rd_chk("R4 high", A_PEND, 32'h1);
    pad_in = 32'h0; settle();
    rd_chk("R4 not held", A_PEND, 32'h0);
    wr(A_POL, 32'h1);
    rd_chk("R4 active low", A_PEND, 32'h1);

    // R5 single edge, R7 clear
    wr(A_POL, 32'h0); wr(A_EDGE, 32'h1); settle();
    wr(A_PCLR, 32'hFFFF_FFFF);
    rd_chk("R5 armed", A_PEND, 32'h0);
    pad_in = 32'h1; settle();
    rd_chk("R5 rise", A_PEND, 32'h1);
    pad_in = 32'h0; settle();
    rd_chk("R5 held", A_PEND, 32'h1);
    wr(A_PCLR, 32'h0);
    rd_chk("R7 zero no effect", A_PEND, 32'h1);
    rd_chk("R7 read zero", A_PCLR, 32'h0);
    wr(A_PCLR, 32'h1);
    rd_chk("R7 cleared", A_PEND, 32'h0);
    wr(A_POL, 32'h1);
    pad_in = 32'h1; settle();
    rd_chk("R5 rise ignored falling", A_PEND, 32'h0);
    pad_in = 32'h0; settle();
    rd_chk("R5 fall", A_PEND, 32'h1);
    wr(A_PCLR, 32'h1);

    // R6 dual edge
    wr(A_DUAL, 32'h1);
    pad_in = 32'h1; settle();
    rd_chk("R6 rise", A_PEND, 32'h1);
    wr(A_PCLR, 32'h1);
    pad_in = 32'h0; settle();
    rd_chk("R6 fall", A_PEND, 32'h1);

    // R8 / R9 mask
    chk("R9 masked", {31'b0, irq}, 32'h0);
    wr(A_MSET, 32'h1);
    rd_chk("R8 set", A_MASK, 32'h1);
    chk("R9 raised", {31'b0, irq}, 32'h1);
    wr(A_MASK, 32'hFFFF_FFFE);
    rd_chk("R8 write-zero clears", A_MASK, 32'h0);
    chk("R9 dropped", {31'b0, irq}, 32'h0);
    rd_chk("R8 mset reads zero", A_MSET, 32'h0);
    wr(A_MSET, 32'h0000_F0F0);
    wr(A_MASK, 32'h0000_FF00);
    rd_chk("R8 and-merge", A_MASK, 32'h0000_F000);

    // R10 latency and decode
    rd_chk("R10 unmapped", 8'h30, 32'h0);
    reg_addr = A_MASK; reg_rd = 1'b1;
    #1 chk("R10 before edge", reg_rdata, 32'h0);
    @(negedge clk); reg_rd = 1'b0;
    chk("R10 after edge", reg_rdata, 32'h0000_F000);
    rd_chk("R10 misaligned", 8'h29, 32'h0);
    wr(8'h29, 32'hFFFF_FFFF);
    rd_chk("R10 misaligned no write", A_MASK, 32'h0000_F000);

    // R11 mode switch discards held status
    rd_chk("R11 pending before", A_PEND, 32'h1);
    wr(A_MODE, 32'h0);
    rd_chk("R11 gpio mode", A_PEND, 32'h0);
    wr(A_MODE, 32'h1);
    rd_chk("R11 not restored", A_PEND, 32'h0);

    // random mixtures against the bench model
    pold = '0;
    for (int it = 0; it < 40; it++) begin
      en = $urandom; mode = $urandom; dir = $urandom; outv = $urandom;
      pol = $urandom; edg = $urandom; dual = $urandom; msk = $urandom;
      wr(A_INEN, en); wr(A_MODE, mode); wr(A_DIR, dir); wr(A_OUTV, outv);
      wr(A_POL, pol); wr(A_EDGE, edg); wr(A_DUAL, dual);
      wr(A_MASK, 32'h0); wr(A_MSET, msk);
      settle();
      wr(A_PCLR, 32'hFFFF_FFFF);
      chk("R2 rand oe", pad_oe, ~mode & dir);
      chk("R2 rand out", pad_out, outv & ~mode & dir);
      qo = pold & en;
      pnew = $urandom;
      pad_in = pnew;
      settle();
      qn = pnew & en;
      lat = exp_hit(mode, edg, pol, dual, qo, qn);
      ep = exp_pend(mode, edg, pol, lat, qn);
      rd_chk("R3 rand pin", A_PIN, qn);
      rd_chk("R4 R5 R6 rand pend", A_PEND, ep);
      chk("R9 rand irq", {31'b0, irq}, {31'b0, |(ep & msk)});
      clr = $urandom;
      wr(A_PCLR, clr);
      lat = lat & ~clr;
      rd_chk("R7 rand clear", A_PEND, exp_pend(mode, edg, pol, lat, qn));
      pold = pnew;
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule